// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel Sequencer

This block is the control sequencer of a single DMA channel that takes its work from descriptors held in memory. Software writes the address of the first descriptor through a two-location configuration port and then sets the run bit. The sequencer reads the four-word descriptor through its memory read port. It then decides from the command word whether to move data at once or to wait for a peripheral request. It drives a transfer engine through an active/done/error handshake and, when the engine finishes, either follows the link word to the next descriptor or halts.

The channel moves through seven states: uninitialised, loaded, fetching, waiting for a request, moving, halted and faulted. The current state is visible on a port. A single interrupt line combines three sources: a write-one-to-clear fetch-complete flag, a sticky fault flag and the halted status. Software can see the run bit still set while the channel is halted, and it clears run to re-arm the channel. The data path, arbitration between channels and direct (descriptor-less) programming are outside this block.

Top module: `dma_desc_seq`

## Requirements
- R1: After reset `chan_state` is 0 (uninitialised), `irq` is 0, and both configuration locations read as 0.
- R2: A write to location 1 (`cfg_sel`=1) while run is 0 and the channel is not fetching, waiting or moving loads the descriptor pointer, enters state 1 (loaded) and clears the fault flag. This holds from the uninitialised, loaded, halted and faulted states.
- R3: With run at 1 in the loaded state, the channel enters state 2 and reads four words in order at pointer[31:4]*16 + 0, 4, 8 and 12: link, source, target and command. Reads only happen in state 2.
- R4: Command bits 29 (target-paced) and 28 (source-paced) both 0 with a nonzero length in bits [15:0] leads directly to state 4 (moving). `xfer_src`, `xfer_dst` and `xfer_len` then show the fetched source, target and length.
- R5: Exactly one of command bits 28 and 29 set leads to state 3 (waiting). The channel stays there until `periph_req` is 1, then enters state 4.
- R6: Both command bits 28 and 29 set makes the descriptor invalid: state 6 (faulted) and the fault flag set.
- R7: When a transfer ends, or a zero-length descriptor with both pacing bits at 0 has been fetched, bit 0 of the link word selects the next step: 1 enters state 5 (halted), 0 loads the link word as the new pointer and fetches from it.
- R8: Every successful fetch sets the start flag (location 0, bit 8). Writing 1 there clears it and writing 0 leaves it. If a fetch completes in the same cycle as the clearing write, the flag ends up set.
- R9: In state 5 the stopped bit (location 0, bit 10) reads 1. After a link-bit halt the run bit (bit 0) still reads 1, and software can write it to 0.
- R10: Writing run (location 0, bit 0) to 0 in states 2, 3 or 4 brings the channel to state 5 one cycle after the run register changes.
- R11: A memory read error during a fetch or a `xfer_err` during a transfer enters state 6 and sets the fault flag (location 0, bit 9). Neither the flag nor the state is left until run is 0 and location 1 is written.
- R12: In state 6 `mem_rd_req` and `xfer_active` stay 0 and `periph_req` has no effect.
- R13: `irq` = (start flag AND start enable, bit 1) OR fault flag OR (stopped AND stop enable, bit 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Location select: 0 control/status, 1 descriptor pointer |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data of the selected location |
| mem_rd_req | output | 1 | Descriptor word read request |
| mem_rd_addr | output | 32 | Byte address of the requested word |
| mem_rd_valid | input | 1 | Read response valid |
| mem_rd_data | input | 32 | Read response data |
| mem_rd_err | input | 1 | Read response carries a bus error |
| periph_req | input | 1 | Peripheral request for paced transfers |
| xfer_active | output | 1 | Transfer engine is commanded to move data |
| xfer_src | output | 32 | Source address of the current descriptor |
| xfer_dst | output | 32 | Target address of the current descriptor |
| xfer_len | output | 16 | Length of the current descriptor |
| xfer_done | input | 1 | Transfer engine finished |
| xfer_err | input | 1 | Transfer engine hit a bus error |
| irq | output | 1 | Channel interrupt |
| chan_state | output | 3 | Channel state code |

## Verification
The sharpest collision is a fetch completing in the same clock as a software write that clears the start flag. The bench provokes it by watching for the read request to drop while the channel is still fetching, which marks the last cycle before completion, and it issues the clearing write exactly then. The flag must read 1 afterwards, because a newly finished fetch must not be swallowed by the acknowledgement of an older one. A second overlap, run cleared while the transfer engine holds its done line back, is judged by the channel reaching the halted state rather than chaining.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [2:0] {
    CH_UNINIT  = 3'd0,
    CH_LOADED  = 3'd1,
    CH_FETCH   = 3'd2,
    CH_WAITREQ = 3'd3,
    CH_MOVE    = 3'd4,
    CH_HALTED  = 3'd5,
    CH_FAULT   = 3'd6
  } ch_state_e;

  typedef enum logic [1:0] {
    ROUTE_FREE  = 2'd0,
    ROUTE_PACED = 2'd1,
    ROUTE_EMPTY = 2'd2,
    ROUTE_BAD   = 2'd3
  } route_e;

  // control/status word bit positions
  localparam int CTL_RUN      = 0;
  localparam int CTL_START_IE = 1;
  localparam int CTL_STOP_IE  = 2;
  localparam int CTL_START_FL = 8;
  localparam int CTL_FAULT_FL = 9;
  localparam int CTL_STOPPED  = 10;

  // descriptor field positions
  localparam int LINK_STOP_BIT = 0;
  localparam int CMD_SRC_PACE  = 28;
  localparam int CMD_DST_PACE  = 29;
  localparam int DESC_WORDS    = 4;

  function automatic route_e route_of(input logic src_pace, input logic dst_pace,
                                      input logic len_zero);
    if (src_pace && dst_pace)      return ROUTE_BAD;
    else if (src_pace ^ dst_pace)  return ROUTE_PACED;
    else if (len_zero)             return ROUTE_EMPTY;
    else                           return ROUTE_FREE;
  endfunction

  function automatic logic irq_of(input logic start_fl, input logic start_ie,
                                  input logic fault_fl, input logic stopped,
                                  input logic stop_ie);
    return (start_fl & start_ie) | fault_fl | (stopped & stop_ie);
  endfunction

  function automatic logic is_busy(input ch_state_e s);
    return (s == CH_FETCH) || (s == CH_WAITREQ) || (s == CH_MOVE);
  endfunction

endpackage

// File: rtl/dma_seq_regs.sv
module dma_seq_regs
  import dma_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  ch_state_e         st,
  input  logic              fetch_ok,
  input  logic              fault_evt,
  input  logic              load_link,
  input  logic [DATA_W-1:0] link_val,
  output logic              run_q,
  output logic              start_flag,
  output logic              err_flag,
  output logic              desc_load,
  output logic [DATA_W-1:0] desc_ptr,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              irq
);

  logic ctl_wr;
  logic start_ie_q;
  logic stop_ie_q;
  logic stopped;

  assign ctl_wr    = cfg_wr & ~cfg_sel;
  assign desc_load = cfg_wr & cfg_sel & ~run_q & ~is_busy(st);
  assign stopped   = (st == CH_HALTED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      start_ie_q <= 1'b0;
      stop_ie_q  <= 1'b0;
    end else if (ctl_wr) begin
      run_q      <= cfg_wdata[CTL_RUN];
      start_ie_q <= cfg_wdata[CTL_START_IE];
      stop_ie_q  <= cfg_wdata[CTL_STOP_IE];
    end
  end

  // a newly completed fetch outranks a simultaneous acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                start_flag <= 1'b0;
    else if (fetch_ok)                         start_flag <= 1'b1;
    else if (ctl_wr && cfg_wdata[CTL_START_FL]) start_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err_flag <= 1'b0;
    else if (fault_evt) err_flag <= 1'b1;
    else if (desc_load) err_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         desc_ptr <= '0;
    else if (load_link) desc_ptr <= link_val;
    else if (desc_load) desc_ptr <= cfg_wdata;
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_sel) begin
      cfg_rdata = desc_ptr;
    end else begin
      cfg_rdata[CTL_RUN]      = run_q;
      cfg_rdata[CTL_START_IE] = start_ie_q;
      cfg_rdata[CTL_STOP_IE]  = stop_ie_q;
      cfg_rdata[CTL_START_FL] = start_flag;
      cfg_rdata[CTL_FAULT_FL] = err_flag;
      cfg_rdata[CTL_STOPPED]  = stopped;
    end
  end

  assign irq = irq_of(start_flag, start_ie_q, err_flag, stopped, stop_ie_q);

endmodule

// File: rtl/dma_seq_fetch.sv
module dma_seq_fetch
  import dma_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              restart,
  input  logic [DATA_W-1:0] base,
  output logic              mem_rd_req,
  output logic [DATA_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  input  logic              mem_rd_err,
  output logic              fetch_done,
  output logic              fetch_fault,
  output logic [DATA_W-1:0] link_w,
  output logic [DATA_W-1:0] src_w,
  output logic [DATA_W-1:0] dst_w,
  output logic [DATA_W-1:0] cmd_w
);

  localparam int IDX_W  = $clog2(DESC_WORDS);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  logic [IDX_W-1:0]  idx_q;
  logic              done_q;
  logic              take;
  logic [DATA_W-1:0] word_q [DESC_WORDS];

  function automatic logic [DATA_W-1:0] word_addr(input logic [DATA_W-1:0] b,
                                                  input logic [IDX_W-1:0] i);
    logic [DATA_W-1:0] a;
    a = b;
    a[IDX_W+BYTE_W-1:0] = {i, {BYTE_W{1'b0}}};
    return a;
  endfunction

  assign mem_rd_req  = active & ~done_q;
  assign mem_rd_addr = word_addr(base, idx_q);
  assign take        = mem_rd_req & mem_rd_valid & ~mem_rd_err;
  assign fetch_fault = mem_rd_req & mem_rd_valid & mem_rd_err;
  assign fetch_done  = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      done_q <= 1'b0;
    end else if (!active || restart) begin
      idx_q  <= '0;
      done_q <= 1'b0;
    end else if (take) begin
      if (idx_q == LAST_IDX) done_q <= 1'b1;
      else                   idx_q  <= idx_q + 1'b1;
    end
  end

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             word_q[g] <= '0;
      else if (take && idx_q == IDX_W'(g))    word_q[g] <= mem_rd_data;
    end
  end

  assign link_w = word_q[0];
  assign src_w  = word_q[1];
  assign dst_w  = word_q[2];
  assign cmd_w  = word_q[3];

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              desc_load,
  input  logic              fetch_done,
  input  logic              fetch_fault,
  input  logic [DATA_W-1:0] cmd_w,
  input  logic [DATA_W-1:0] link_w,
  input  logic              periph_req,
  input  logic              xfer_done,
  input  logic              xfer_err,
  output ch_state_e         st,
  output logic              fetch_ok,
  output logic              fault_evt,
  output logic              load_link,
  output logic              xfer_active
);

  ch_state_e nxt;
  route_e    route;
  logic      len_zero;
  logic      link_stop;

  assign len_zero  = (cmd_w[LEN_W-1:0] == '0);
  assign route     = route_of(cmd_w[CMD_SRC_PACE], cmd_w[CMD_DST_PACE], len_zero);
  assign link_stop = link_w[LINK_STOP_BIT];

  always_comb begin
    nxt       = st;
    fetch_ok  = 1'b0;
    fault_evt = 1'b0;
    load_link = 1'b0;
    case (st)
      CH_UNINIT, CH_LOADED, CH_HALTED, CH_FAULT: begin
        if (desc_load)                    nxt = CH_LOADED;
        else if (st == CH_LOADED && run)  nxt = CH_FETCH;
      end
      CH_FETCH: begin
        if (!run) begin
          nxt = CH_HALTED;
        end else if (fetch_fault) begin
          nxt       = CH_FAULT;
          fault_evt = 1'b1;
        end else if (fetch_done) begin
          fetch_ok = (route != ROUTE_BAD);
          case (route)
            ROUTE_FREE:  nxt = CH_MOVE;
            ROUTE_PACED: nxt = CH_WAITREQ;
            ROUTE_BAD: begin
              nxt       = CH_FAULT;
              fault_evt = 1'b1;
            end
            default: begin
              if (link_stop) nxt = CH_HALTED;
              else begin
                nxt       = CH_FETCH;
                load_link = 1'b1;
              end
            end
          endcase
        end
      end
      CH_WAITREQ: begin
        if (!run)            nxt = CH_HALTED;
        else if (periph_req) nxt = CH_MOVE;
      end
      CH_MOVE: begin
        if (!run) begin
          nxt = CH_HALTED;
        end else if (xfer_err) begin
          nxt       = CH_FAULT;
          fault_evt = 1'b1;
        end else if (xfer_done) begin
          if (link_stop) nxt = CH_HALTED;
          else begin
            nxt       = CH_FETCH;
            load_link = 1'b1;
          end
        end
      end
      default: nxt = CH_UNINIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= CH_UNINIT;
    else        st <= nxt;
  end

  assign xfer_active = (st == CH_MOVE);

endmodule

// File: rtl/dma_desc_seq.sv
module dma_desc_seq
  import dma_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              mem_rd_req,
  output logic [DATA_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  input  logic              mem_rd_err,
  input  logic              periph_req,
  output logic              xfer_active,
  output logic [DATA_W-1:0] xfer_src,
  output logic [DATA_W-1:0] xfer_dst,
  output logic [LEN_W-1:0]  xfer_len,
  input  logic              xfer_done,
  input  logic              xfer_err,
  output logic              irq,
  output logic [2:0]        chan_state
);

  ch_state_e         st;
  logic              run_q;
  logic              start_flag;
  logic              err_flag;
  logic              desc_load;
  logic [DATA_W-1:0] desc_ptr;
  logic              fetch_ok;
  logic              fault_evt;
  logic              load_link;
  logic              fetch_done;
  logic              fetch_fault;
  logic [DATA_W-1:0] link_w, src_w, dst_w, cmd_w;

  dma_seq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .st(st), .fetch_ok(fetch_ok), .fault_evt(fault_evt),
    .load_link(load_link), .link_val(link_w),
    .run_q(run_q), .start_flag(start_flag), .err_flag(err_flag),
    .desc_load(desc_load), .desc_ptr(desc_ptr),
    .cfg_rdata(cfg_rdata), .irq(irq)
  );

  dma_seq_fetch #(.DATA_W(DATA_W)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .active(st == CH_FETCH), .restart(load_link), .base(desc_ptr),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .mem_rd_err(mem_rd_err),
    .fetch_done(fetch_done), .fetch_fault(fetch_fault),
    .link_w(link_w), .src_w(src_w), .dst_w(dst_w), .cmd_w(cmd_w)
  );

  dma_seq_fsm #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .run(run_q), .desc_load(desc_load),
    .fetch_done(fetch_done), .fetch_fault(fetch_fault),
    .cmd_w(cmd_w), .link_w(link_w),
    .periph_req(periph_req), .xfer_done(xfer_done), .xfer_err(xfer_err),
    .st(st), .fetch_ok(fetch_ok), .fault_evt(fault_evt),
    .load_link(load_link), .xfer_active(xfer_active)
  );

  assign xfer_src   = src_w;
  assign xfer_dst   = dst_w;
  assign xfer_len   = cmd_w[LEN_W-1:0];
  assign chan_state = st;

endmodule

// File: rtl/dma_desc_seq_chk.sv
module dma_desc_seq_chk
  import dma_seq_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input ch_state_e st,
  input logic      run_q,
  input logic      periph_req,
  input logic      mem_rd_req,
  input logic      xfer_active,
  input logic      fetch_ok,
  input logic      start_flag,
  input logic      err_flag,
  input logic      desc_load
);

  logic busy;
  assign busy = (st == CH_FETCH) || (st == CH_WAITREQ) || (st == CH_MOVE);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> st == CH_UNINIT);

  assert_read_in_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> st == CH_FETCH);

  assert_wait_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CH_WAITREQ && run_q && !periph_req) |=> st == CH_WAITREQ);

  assert_start_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ok |=> start_flag);

  assert_run_clear_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !run_q) |=> st == CH_HALTED);

  assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !desc_load) |=> err_flag);

  assert_fault_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    st == CH_FAULT |-> (!mem_rd_req && !xfer_active));

endmodule

bind dma_desc_seq dma_desc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .run_q(run_q), .periph_req(periph_req),
  .mem_rd_req(mem_rd_req), .xfer_active(xfer_active), .fetch_ok(fetch_ok),
  .start_flag(start_flag), .err_flag(err_flag), .desc_load(desc_load)
);

// File: tb/sim_dma_desc_seq.sv
module sim_dma_desc_seq;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RUN = 32'h1, SIE = 32'h2, PIE = 32'h4, ACK = 32'h100;
  localparam logic [2:0] S_UN = 0, S_LD = 1, S_FE = 2, S_WT = 3, S_MV = 4, S_HA = 5, S_FA = 6;
  // vector: [1:0] {target pace, source pace}, [2] zero length, [3] link stop, [6:4] state after fetch
  localparam logic [7:0] VEC [5] = '{
    8'b0_100_1_0_00, 8'b0_011_1_0_01, 8'b0_011_1_0_10, 8'b0_110_1_0_11, 8'b0_101_1_1_00 };

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, cfg_sel = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic mem_rd_req, mem_rd_valid = 0, mem_rd_err = 0;
  logic [31:0] mem_rd_addr, mem_rd_data = 0;
  logic periph_req = 0, xfer_active, xfer_done = 0, xfer_err = 0, irq;
  logic [31:0] xfer_src, xfer_dst;
  logic [15:0] xfer_len;
  logic [2:0] chan_state;

  logic [31:0] mem [64];
  logic [31:0] log_a [32];
  int log_n = 0, eng_cnt = 0, nchk = 0, nerr = 0;
  logic err_on = 0, eng_hold = 0, eng_fail = 0;
  logic [31:0] err_addr = 0, rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_desc_seq u0 (.*);

  always @(negedge clk) begin
    mem_rd_valid <= mem_rd_req;
    mem_rd_data  <= mem[mem_rd_addr[7:2]];
    mem_rd_err   <= mem_rd_req && err_on && (mem_rd_addr == err_addr);
    if (mem_rd_req && log_n < 32) begin
      log_a[log_n] <= mem_rd_addr;
      log_n <= log_n + 1;
    end
  end

  always @(negedge clk) begin
    xfer_done <= 0; xfer_err <= 0;
    if (xfer_active && !eng_hold) begin
      if (eng_cnt == 2) begin
        xfer_done <= !eng_fail; xfer_err <= eng_fail; eng_cnt <= 0;
      end else eng_cnt <= eng_cnt + 1;
    end else eng_cnt <= 0;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic s, input logic [31:0] d);
    cfg_sel = s; cfg_wdata = d; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic rd(input logic s, output logic [31:0] d);
    cfg_sel = s; #1; d = cfg_rdata;
  endtask

  task automatic put_desc(input int w, input logic [31:0] lk, sa, da, cm);
    mem[w] = lk; mem[w+1] = sa; mem[w+2] = da; mem[w+3] = cm;
  endtask

  function automatic logic [31:0] mkcmd(input logic sp, input logic dp, input logic [15:0] len);
    return {2'b00, dp, sp, 12'h0, len};
  endfunction

  task automatic wait_leave();
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (chan_state != S_LD && chan_state != S_FE) break;
    end
  endtask

  task automatic wait_state(input logic [2:0] s, input int n);
    for (int i = 0; i < n; i++) begin
      if (chan_state == s) break;
      @(negedge clk);
    end
  endtask

  task automatic reinit(input logic [31:0] ptr);
    wr(0, ACK);
    wr(1, ptr);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 0;
    tick(3);
    rst_n = 1;
    tick(1);
    // reset state
    chk("R1 state", chan_state, S_UN);
    chk("R1 irq", irq, 0);
    rd(0, rv); chk("R1 ctrl", rv, 0);
    rd(1, rv); chk("R1 ptr", rv, 0);

    // table walk over command routing
    for (int v = 0; v < 5; v++) begin
      logic [7:0] e;
      e = VEC[v];
      reinit(0);
      chk("R2 loaded", chan_state, S_LD);
      rd(0, rv); chk("R2 fault cleared", rv[9], 0);
      put_desc(0, 32'h1, 32'h1000 + v, 32'h2000 + v, mkcmd(e[0], e[1], e[2] ? 16'd0 : 16'd8));
      wr(0, RUN);
      wait_leave();
      chk("R4 R5 R6 R7 route", chan_state, e[6:4]);
      if (e[6:4] == S_MV) begin
        chk("R4 src", xfer_src, 32'h1000 + v);
        chk("R4 dst", xfer_dst, 32'h2000 + v);
        chk("R4 len", xfer_len, 8);
        wait_state(S_HA, 20);
        chk("R7 halt on stop link", chan_state, S_HA);
      end else if (e[6:4] == S_WT) begin
        tick(3);
        chk("R5 waits for request", chan_state, S_WT);
        periph_req = 1;
        tick(1);
        chk("R5 request starts move", chan_state, S_MV);
        periph_req = 0;
        wait_state(S_HA, 20);
        chk("R7 halt after paced move", chan_state, S_HA);
      end else if (e[6:4] == S_FA) begin
        rd(0, rv); chk("R6 fault flag", rv[9], 1);
      end
    end

    // chained descriptors
    reinit(0);
    put_desc(0, 32'h10, 32'hA0, 32'hB0, mkcmd(0, 0, 16'd4));
    put_desc(4, 32'h21, 32'hC0, 32'hD0, mkcmd(0, 0, 16'd2));
    log_n = 0;
    wr(0, RUN);
    wait_state(S_HA, 60);
    chk("R7 chain halts", chan_state, S_HA);
    chk("R3 read count", log_n, 8);
    for (int i = 0; i < 8; i++) chk("R3 read address", log_a[i], 32'(4 * i));
    rd(1, rv); chk("R7 pointer follows link", rv, 32'h10);
    rd(0, rv);
    chk("R9 run still set", rv[0], 1);
    chk("R9 stopped bit", rv[10], 1);
    chk("R8 start flag set", rv[8], 1);
    chk("R13 no enables", irq, 0);
    wr(0, RUN | PIE);
    chk("R13 stop enable", irq, 1);
    wr(0, RUN);
    rd(0, rv); chk("R8 write zero keeps", rv[8], 1);
    wr(0, RUN | ACK);
    rd(0, rv); chk("R8 write one clears", rv[8], 0);
    wr(0, 0);
    rd(0, rv);
    chk("R9 run cleared", rv[0], 0);
    chk("R9 still halted", chan_state, S_HA);

    // collision of fetch completion and acknowledge
    reinit(0);
    put_desc(0, 32'h1, 32'h1, 32'h2, mkcmd(1, 0, 16'd4));
    wr(0, RUN | SIE);
    for (int i = 0; i < 30; i++) begin
      if (chan_state == S_FE && !mem_rd_req) break;
      @(negedge clk);
    end
    wr(0, RUN | SIE | ACK);
    chk("R5 parked waiting", chan_state, S_WT);
    rd(0, rv); chk("R8 set wins over clear", rv[8], 1);
    chk("R13 start enable", irq, 1);
    wr(0, RUN | SIE | ACK);
    chk("R13 irq drops after clear", irq, 0);
    // run cleared while waiting
    wr(0, 0);
    tick(1);
    chk("R10 wait to halt", chan_state, S_HA);

    // run cleared while moving
    reinit(0);
    put_desc(0, 32'h0, 32'h1, 32'h2, mkcmd(0, 0, 16'd4));
    eng_hold = 1;
    wr(0, RUN);
    wait_state(S_MV, 20);
    wr(0, 0);
    tick(1);
    chk("R10 move to halt", chan_state, S_HA);
    eng_hold = 0;

    // bus error during fetch
    reinit(0);
    put_desc(0, 32'h1, 32'h1, 32'h2, mkcmd(0, 0, 16'd4));
    err_on = 1; err_addr = 32'h8;
    wr(0, RUN);
    wait_leave();
    err_on = 0;
    chk("R11 fetch error faults", chan_state, S_FA);
    rd(0, rv); chk("R11 fault flag", rv[9], 1);
    chk("R13 fault irq", irq, 1);
    periph_req = 1;
    for (int i = 0; i < 5; i++) begin
      tick(1);
      chk("R12 state held", chan_state, S_FA);
      chk("R12 no reads", mem_rd_req, 0);
      chk("R12 no move", xfer_active, 0);
    end
    periph_req = 0;
    wr(0, RUN);
    wr(1, 32'h0);
    chk("R11 no exit while run", chan_state, S_FA);
    rd(0, rv); chk("R11 sticky flag", rv[9], 1);
    wr(0, 0);
    wr(1, 32'h0);
    chk("R2 leave fault", chan_state, S_LD);
    rd(0, rv); chk("R11 flag cleared", rv[9], 0);
    chk("R13 irq quiet", irq, 0);

    // bus error during transfer
    eng_fail = 1;
    wr(0, RUN);
    wait_state(S_FA, 40);
    eng_fail = 0;
    chk("R11 transfer error faults", chan_state, S_FA);
    rd(0, rv); chk("R11 transfer fault flag", rv[9], 1);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule